// File: doc/BRIEF.md
# Time-Multiplexed Four-Channel FIR Filter

This block filters four independent streams of 16-bit two's complement samples with 150-tap FIR filters. One multiply-accumulate engine does all the arithmetic. A single strobe delivers one new sample per channel. The block writes the four samples into per-channel circular delay lines. A sequencer then walks every tap of channel 0, then channel 1, then channel 2, then channel 3. For each tap it reads the delayed sample and the matching coefficient, multiplies them, and adds the product into that channel's own accumulator. When the work is done, four rounded and saturated results appear together with a one-cycle valid pulse.

Channels 0, 1 and 2 share one coefficient bank, and channel 3 has a second bank. The MAC path is pipelined and issues one tap per clock, so a full update takes about 604 cycles. This fits easily inside a 10,000-cycle sample period at a 10 MHz core clock with a 1 kHz sample rate.

The sequencer has five states:
- CLEAR: sweeps zeros into all delay-line addresses after reset, then moves to IDLE.
- IDLE: waits for a strobe. An accepted strobe moves to RUN.
- RUN: issues one tap per cycle. After the last tap of the last channel it moves to DRAIN.
- DRAIN: waits for the two pipeline stages to empty, then moves to DONE.
- DONE: latches the results, advances the write pointer and returns to IDLE.

Top module: `fir_mc_top`

## Requirements
- R1: While reset is asserted, `ready`, `out_vld` and `ovr` are low. After reset is released, `ready` stays low for at least 150 cycles while the delay lines are zeroed, and then goes high.
- R2: A strobe on `in_stb` while `ready` is high is accepted. Channel c takes its sample from `in_smp[16c+15:16c]`. `ready` is low from the next cycle until the result is reported.
- R3: For each channel c, the result equals sat16(((sum over k=0..149 of h_c[k]·x_c[n−k]) + 2^14) >>> 15). Here x_c[n] is the sample just accepted, and any sample older than the clear sweep counts as zero.
- R4: Channels 0, 1 and 2 use h_A[k] = ((73·k) mod 601) − 300. Channel 3 uses h_B[k] = 4000 − 50·k. The channels do not affect one another.
- R5: Rounding is half-up. A sum whose fractional part is exactly one half rounds toward plus infinity, for both positive and negative sums.
- R6: A rounded value above 32767 is reported as 32767, and one below −32768 is reported as −32768.
- R7: The accumulators are 40 bits wide and never overflow, even with full-scale inputs on every tap.
- R8: `out_vld` is a one-cycle pulse. It comes no later than 620 cycles after the cycle in which the strobe was accepted, and `ready` is high in that cycle. `out_y` holds its value until the next pulse; channel c's result is in `out_y[16c+15:16c]`.
- R9: A strobe while `ready` is low, including during the clear sweep, drives `ovr` high for exactly the following cycle. Its samples are dropped and never enter any delay line.
- R10: Each accepted sample contributes to its channel's results for exactly 150 sample periods, at taps 0 to 149. From the 151st result on it no longer contributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | New-sample strobe for all channels |
| in_smp | input | 64 | Four packed signed samples, channel 0 in the low bits |
| ready | output | 1 | High when a strobe will be accepted |
| ovr | output | 1 | Pulses after a strobe that was dropped |
| out_vld | output | 1 | One-cycle pulse when `out_y` is updated |
| out_y | output | 64 | Four packed signed filtered results |

## Verification
The bench uses three input patterns.

First, an impulse is fed on every channel, followed by 151 periods of zeros. This reads back each coefficient one tap at a time. It also separates the two coefficient banks, and it shows whether the sample ages out of the delay line at the right period. The impulse values of ±16384 make every odd coefficient land exactly on a half. This separates half-up rounding from truncation and from round-to-even.

Second, a pseudo-random stream with different values per channel catches crosstalk between channels and errors in the circular addressing.

Third, long runs of full-scale positive and negative samples drive channel 3 into both saturation limits and stress the accumulator width. Strobes sent while the block is busy, or during the clear sweep, show whether dropped samples leak into later results.

// File: rtl/fir_mc_pkg.sv
package fir_mc_pkg;

    typedef enum logic [2:0] {
        SEQ_CLEAR,
        SEQ_IDLE,
        SEQ_RUN,
        SEQ_DRAIN,
        SEQ_DONE
    } seq_state_e;

    // Coefficient generator: bank 0 is shared by the first channels,
    // bank 1 belongs to the last channel.
    function automatic int coef_value(input int bank, input int k);
        if (bank == 0) begin
            return ((k * 73) % 601) - 300;
        end
        return 4000 - 50 * k;
    endfunction

endpackage

// File: rtl/fir_delay_ram.sv
module fir_delay_ram #(
    parameter  int DW    = 16,
    parameter  int DEPTH = 150,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/fir_coef_rom.sv
module fir_coef_rom
    import fir_mc_pkg::*;
#(
    parameter  int CW    = 16,
    parameter  int NTAP  = 150,
    parameter  int NBANK = 2,
    localparam int DEPTH = NBANK * NTAP,
    localparam int KW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic [KW-1:0]        addr,
    output logic signed [CW-1:0] coef
);

    logic signed [CW-1:0] rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign rom[i] = CW'(coef_value(i / NTAP, i % NTAP));
    end

    always_ff @(posedge clk) begin
        coef <= rom[addr];
    end

endmodule

// File: rtl/fir_seq_ctrl.sv
module fir_seq_ctrl
    import fir_mc_pkg::*;
#(
    parameter  int NCH     = 4,
    parameter  int NTAP    = 150,
    parameter  int PIPE    = 2,
    localparam int AW      = $clog2(NTAP),
    localparam int CHW     = $clog2(NCH),
    localparam int KW      = $clog2(2 * NTAP),
    localparam int DRW     = $clog2(PIPE + 1),
    localparam int RUN_MAX = NCH * NTAP + PIPE + 2,
    localparam int RCW     = $clog2(RUN_MAX + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_stb,
    output logic           ready,
    output logic           ovr,
    output logic           ram_we,
    output logic           ram_clr,
    output logic [AW-1:0]  ram_waddr,
    output logic [AW-1:0]  rd_addr,
    output logic [KW-1:0]  coef_addr,
    output logic           iss_vld,
    output logic [CHW-1:0] iss_ch,
    output logic           acc_clr,
    output logic           out_latch
);

    localparam logic [AW-1:0]  LAST_TAP = AW'(NTAP - 1);
    localparam logic [CHW-1:0] LAST_CH  = CHW'(NCH - 1);
    localparam logic [DRW-1:0] LAST_DRN = DRW'(PIPE - 1);

    seq_state_e     state, nxt;
    logic [AW-1:0]  clr_cnt;
    logic [AW-1:0]  wp;
    logic [AW-1:0]  tap;
    logic [CHW-1:0] ch;
    logic [DRW-1:0] drn;
    logic [AW:0]    wrap_sum;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_CLEAR;
        end else begin
            state <= nxt;
        end
    end

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_CLEAR: if (clr_cnt == LAST_TAP) nxt = SEQ_IDLE;
            SEQ_IDLE:  if (in_stb) nxt = SEQ_RUN;
            SEQ_RUN:   if (ch == LAST_CH && tap == LAST_TAP) nxt = SEQ_DRAIN;
            SEQ_DRAIN: if (drn == LAST_DRN) nxt = SEQ_DONE;
            SEQ_DONE:  nxt = SEQ_IDLE;
            default:   nxt = SEQ_CLEAR;
        endcase
    end

    // Counters and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_cnt <= '0;
            wp      <= '0;
            tap     <= '0;
            ch      <= '0;
            drn     <= '0;
            ovr     <= 1'b0;
        end else begin
            ovr <= in_stb && (state != SEQ_IDLE);
            unique case (state)
                SEQ_CLEAR: clr_cnt <= clr_cnt + 1'b1;
                SEQ_IDLE: begin
                    tap <= '0;
                    ch  <= '0;
                end
                SEQ_RUN: begin
                    if (tap == LAST_TAP) begin
                        tap <= '0;
                        ch  <= ch + 1'b1;
                    end else begin
                        tap <= tap + 1'b1;
                    end
                end
                SEQ_DRAIN: drn <= drn + 1'b1;
                SEQ_DONE: begin
                    drn <= '0;
                    wp  <= (wp == LAST_TAP) ? '0 : wp + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Circular read address: (wp - tap) mod NTAP
    always_comb begin
        wrap_sum = {1'b0, wp} + (AW + 1)'(NTAP) - {1'b0, tap};
        if (wp >= tap) begin
            rd_addr = wp - tap;
        end else begin
            rd_addr = wrap_sum[AW-1:0];
        end
    end

    // Outputs
    always_comb begin
        ready     = 1'b0;
        ram_we    = 1'b0;
        ram_clr   = 1'b0;
        ram_waddr = wp;
        iss_vld   = 1'b0;
        acc_clr   = 1'b0;
        out_latch = 1'b0;
        iss_ch    = ch;
        coef_addr = (ch == LAST_CH) ? KW'(NTAP) + KW'(tap) : KW'(tap);
        unique case (state)
            SEQ_CLEAR: begin
                ram_we    = 1'b1;
                ram_clr   = 1'b1;
                ram_waddr = clr_cnt;
            end
            SEQ_IDLE: begin
                ready   = 1'b1;
                ram_we  = in_stb;
                acc_clr = in_stb;
            end
            SEQ_RUN:   iss_vld = 1'b1;
            SEQ_DRAIN: ;
            SEQ_DONE:  out_latch = 1'b1;
            default: ;
        endcase
    end

    // Checker counters
    logic [AW:0]     boot_cnt;
    logic [RCW-1:0]  run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_cnt <= '0;
            run_cnt  <= '0;
        end else begin
            if (boot_cnt != (AW + 1)'(NTAP)) boot_cnt <= boot_cnt + 1'b1;
            if (acc_clr) begin
                run_cnt <= RCW'(1);
            end else if (!ready && run_cnt != '0 && run_cnt != RCW'(RUN_MAX + 1)) begin
                run_cnt <= run_cnt + 1'b1;
            end else if (ready) begin
                run_cnt <= '0;
            end
        end
    end

    p_clear_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> boot_cnt == (AW + 1)'(NTAP));

    p_run_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= RCW'(RUN_MAX));

    p_rd_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> 32'(rd_addr) < NTAP);

    p_wr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> 32'(ram_waddr) < NTAP);

endmodule

// File: rtl/fir_mac_dp.sv
module fir_mac_dp #(
    parameter  int NCH   = 4,
    parameter  int DW    = 16,
    parameter  int CW    = 16,
    parameter  int ACCW  = 40,
    parameter  int SHIFT = 15,
    localparam int CHW   = $clog2(NCH),
    localparam int PW    = DW + CW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_vld,
    input  logic [CHW-1:0]       iss_ch,
    input  logic [NCH*DW-1:0]    smp_rd,
    input  logic signed [CW-1:0] coef_rd,
    input  logic                 acc_clr,
    input  logic                 out_latch,
    output logic                 out_vld,
    output logic [NCH*DW-1:0]    out_y
);

    localparam logic signed [ACCW-1:0] RHALF = ACCW'(1) <<< (SHIFT - 1);
    localparam logic signed [ACCW-1:0] YMAX  = ACCW'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam logic signed [ACCW-1:0] YMIN  = -YMAX - ACCW'(1);

    logic                   vld1, vld2;
    logic [CHW-1:0]         ch1, ch2;
    logic [DW-1:0]          smp_sel;
    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] acc [NCH];
    logic signed [ACCW-1:0] acc_sum;
    logic [NCH*DW-1:0]      y_next;

    assign smp_sel = smp_rd[ch1*DW +: DW];
    assign acc_sum = acc[ch2] + ACCW'(prod);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld1    <= 1'b0;
            vld2    <= 1'b0;
            ch1     <= '0;
            ch2     <= '0;
            prod    <= '0;
            out_vld <= 1'b0;
            out_y   <= '0;
            for (int c = 0; c < NCH; c++) acc[c] <= '0;
        end else begin
            vld1    <= iss_vld;
            ch1     <= iss_ch;
            vld2    <= vld1;
            ch2     <= ch1;
            prod    <= $signed({{CW{smp_sel[DW-1]}}, smp_sel})
                     * $signed({{DW{coef_rd[CW-1]}}, coef_rd});
            for (int c = 0; c < NCH; c++) begin
                if (acc_clr) begin
                    acc[c] <= '0;
                end else if (vld2 && ch2 == CHW'(c)) begin
                    acc[c] <= acc_sum;
                end
            end
            out_vld <= out_latch;
            if (out_latch) out_y <= y_next;
        end
    end

    // Round half up, then clamp to the output range
    for (genvar c = 0; c < NCH; c++) begin : g_rnd
        logic signed [ACCW-1:0] shr;
        always_comb begin
            shr = (acc[c] + RHALF) >>> SHIFT;
            if (shr > YMAX) begin
                y_next[c*DW +: DW] = YMAX[DW-1:0];
            end else if (shr < YMIN) begin
                y_next[c*DW +: DW] = YMIN[DW-1:0];
            end else begin
                y_next[c*DW +: DW] = shr[DW-1:0];
            end
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld2 && acc[ch2][ACCW-1] == prod[PW-1]) |-> acc_sum[ACCW-1] == prod[PW-1]);

    p_vld_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld);

endmodule

// File: rtl/fir_mc_top.sv
module fir_mc_top #(
    parameter  int NCH   = 4,
    parameter  int NTAP  = 150,
    parameter  int DW    = 16,
    parameter  int CW    = 16,
    parameter  int ACCW  = 40,
    parameter  int SHIFT = 15,
    localparam int AW    = $clog2(NTAP),
    localparam int CHW   = $clog2(NCH),
    localparam int KW    = $clog2(2 * NTAP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_stb,
    input  logic [NCH*DW-1:0] in_smp,
    output logic              ready,
    output logic              ovr,
    output logic              out_vld,
    output logic [NCH*DW-1:0] out_y
);

    logic                 ram_we, ram_clr;
    logic [AW-1:0]        ram_waddr, rd_addr;
    logic [KW-1:0]        coef_addr;
    logic                 iss_vld, acc_clr, out_latch;
    logic [CHW-1:0]       iss_ch;
    logic [NCH*DW-1:0]    smp_rd;
    logic signed [CW-1:0] coef_rd;

    fir_seq_ctrl #(.NCH(NCH), .NTAP(NTAP), .PIPE(2)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_stb    (in_stb),
        .ready     (ready),
        .ovr       (ovr),
        .ram_we    (ram_we),
        .ram_clr   (ram_clr),
        .ram_waddr (ram_waddr),
        .rd_addr   (rd_addr),
        .coef_addr (coef_addr),
        .iss_vld   (iss_vld),
        .iss_ch    (iss_ch),
        .acc_clr   (acc_clr),
        .out_latch (out_latch)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_line
        logic [DW-1:0] wdata;
        assign wdata = ram_clr ? '0 : in_smp[c*DW +: DW];
        fir_delay_ram #(.DW(DW), .DEPTH(NTAP)) i_ram (
            .clk   (clk),
            .we    (ram_we),
            .waddr (ram_waddr),
            .wdata (wdata),
            .raddr (rd_addr),
            .rdata (smp_rd[c*DW +: DW])
        );
    end

    fir_coef_rom #(.CW(CW), .NTAP(NTAP), .NBANK(2)) i_rom (
        .clk  (clk),
        .addr (coef_addr),
        .coef (coef_rd)
    );

    fir_mac_dp #(.NCH(NCH), .DW(DW), .CW(CW), .ACCW(ACCW), .SHIFT(SHIFT)) i_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_vld   (iss_vld),
        .iss_ch    (iss_ch),
        .smp_rd    (smp_rd),
        .coef_rd   (coef_rd),
        .acc_clr   (acc_clr),
        .out_latch (out_latch),
        .out_vld   (out_vld),
        .out_y     (out_y)
    );

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && ready) |=> !ready);

    p_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && !ready) |=> ovr);

    p_vld_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ready);

endmodule

// File: tb/test_fir_mc_top.sv
module test_fir_mc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_stb = 1'b0;
    logic [63:0] in_smp = '0;
    logic        ready, ovr, out_vld;
    logic [63:0] out_y;

    int tests = 0;
    int fails = 0;
    int hist [4][150];
    int sat_hi = 0;
    int sat_lo = 0;

    always #4 clk = ~clk;

    fir_mc_top i_fir_mc_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_stb  (in_stb),
        .in_smp  (in_smp),
        .ready   (ready),
        .ovr     (ovr),
        .out_vld (out_vld),
        .out_y   (out_y)
    );

    function automatic longint hcoef(input int ch, input int k);
        if (ch == 3) return longint'(4000 - 50 * k);
        return longint'(((73 * k) % 601) - 300);
    endfunction

    function automatic longint expect_y(input int ch);
        longint s = 0;
        longint r;
        for (int k = 0; k < 150; k++) s += hcoef(ch, k) * longint'(hist[ch][k]);
        r = (s + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic run_period(input int s0, input int s1, input int s2, input int s3,
                              input string req, input bit with_ovr);
        int s [4];
        int cnt;
        logic [63:0] held;
        s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
        cnt = 0;
        while (!ready && cnt < 2000) begin
            @(negedge clk);
            cnt++;
        end
        in_smp = {16'(s3), 16'(s2), 16'(s1), 16'(s0)};
        in_stb = 1'b1;
        @(negedge clk);
        in_stb = 1'b0;
        check("R2 ready drops after accept", longint'(ready), 0);
        for (int c = 0; c < 4; c++) begin
            for (int k = 149; k > 0; k--) hist[c][k] = hist[c][k-1];
            hist[c][0] = s[c];
        end
        cnt = 1;
        if (with_ovr) begin
            repeat (10) @(negedge clk);
            cnt += 10;
            in_smp = {16'sd12345, -16'sd9999, 16'sd7777, -16'sd32768};
            in_stb = 1'b1;
            @(negedge clk);
            in_stb = 1'b0;
            cnt++;
            check("R9 ovr after busy strobe", longint'(ovr), 1);
            @(negedge clk);
            cnt++;
            check("R9 ovr single cycle", longint'(ovr), 0);
        end
        while (!out_vld && cnt < 700) begin
            @(negedge clk);
            cnt++;
        end
        check("R8 result latency within 620", longint'(cnt <= 620), 1);
        check("R8 ready high with out_vld", longint'(ready), 1);
        for (int c = 0; c < 4; c++) begin
            longint e = expect_y(c);
            if (e == 32767) sat_hi++;
            if (e == -32768) sat_lo++;
            check(req, longint'($signed(out_y[c*16 +: 16])), e);
        end
        held = out_y;
        @(negedge clk);
        check("R8 out_vld one cycle", longint'(out_vld), 0);
        repeat (3) @(negedge clk);
        check("R8 out_y held", longint'(out_y == held), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt;
        int lfsr;
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 150; k++) hist[c][k] = 0;

        repeat (4) @(negedge clk);
        check("R1 ready low in reset", longint'(ready), 0);
        check("R1 out_vld low in reset", longint'(out_vld), 0);
        check("R1 ovr low in reset", longint'(ovr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready low after reset", longint'(ready), 0);

        // R9: strobe during the clear sweep is dropped
        repeat (2) @(negedge clk);
        in_smp = {16'sd30000, 16'sd30000, 16'sd30000, 16'sd30000};
        in_stb = 1'b1;
        @(negedge clk);
        in_stb = 1'b0;
        check("R9 ovr during clear sweep", longint'(ovr), 1);

        cnt = 4;
        while (!ready && cnt < 400) begin
            @(negedge clk);
            cnt++;
        end
        check("R1 clear sweep length at least 150", longint'(cnt >= 150), 1);
        check("R1 ready rises after sweep", longint'(ready), 1);

        // R5/R4: impulse of +/-16384 gives half-way values on odd taps
        run_period(16384, -16384, 1, 32767, "R5 impulse tap 0", 1'b0);
        for (int p = 1; p < 150; p++)
            run_period(0, 0, 0, 0, "R4 impulse response", 1'b0);
        run_period(0, 0, 0, 0, "R10 sample retired after 150 periods", 1'b0);
        run_period(0, 0, 0, 0, "R10 line empty", 1'b0);

        // R3: independent pseudo-random channels, one period with a busy strobe
        lfsr = 32'h1ACE;
        for (int p = 0; p < 30; p++) begin
            int v [4];
            for (int c = 0; c < 4; c++) begin
                lfsr = (lfsr * 1103515245 + 12345) & 32'h7FFFFFFF;
                v[c] = ((lfsr >>> 8) & 32'hFFFF) - 32768;
            end
            run_period(v[0], v[1], v[2], v[3], "R3 random stream", p == 7);
        end

        // R6/R7: full scale runs drive saturation
        for (int p = 0; p < 14; p++)
            run_period(32767, 32767, -32768, 32767, "R6 positive full scale", 1'b0);
        for (int p = 0; p < 24; p++)
            run_period(-32768, -32768, 32767, -32768, "R7 negative full scale", 1'b0);
        check("R6 upper clamp reached", longint'(sat_hi > 0), 1);
        check("R6 lower clamp reached", longint'(sat_lo > 0), 1);

        finish_run();
    end

endmodule